// File: doc/BRIEF.md
# Parallel Port Configuration Bridge

This block sits between the data and status lines of a PC parallel port and an FPGA that has no configuration yet. It first loads the FPGA: a reset pulse goes out on the FPGA's configuration-reset line, and the block waits for the FPGA to report that its memory is clear. Each rising edge on a conditioned host strobe line then captures one byte from the host data lines. The block places that byte on an 8-bit bus shared with a flash device and a display, and gives the FPGA exactly one configuration clock pulse. While loading, the block holds the FPGA's select, write-strobe and mode-select lines in parallel-load mode and watches the FPGA's clear, hold and ready lines.

When the FPGA raises its ready line, the block turns into a pass-through bridge. Host data is forwarded onto the shared bus, and three FPGA outputs are returned on the host status lines. The display decimal point is lit to show that a valid configuration is loaded. Whenever the FPGA pulls the flash select low, the block releases both the shared bus and the decimal-point line, so the FPGA can reach the flash without contention. If the FPGA's clear line drops during loading before ready rises, the block flags a fault and stays idle until the host pulses its restart line.

The shared bus and the decimal point are modelled as a value plus a drive enable. Host strobe and restart are asynchronous and pass through a synchronizer with edge detection. All other inputs are taken as synchronous to `clk`.

Top module: `pport_cfg_bridge`

## Requirements
- R1: While `rst` is high, `shared_bus_oe`, `dot_oe` and `fpga_cfg_clk` are 0, and `host_status` is 0.
- R2: After reset is released, or after a rising edge on `host_restart`, `fpga_reset_n` is low for exactly PROG_LEN clock cycles. Strobes are then ignored until `fpga_clear_n` is high.
- R3: While loading, each rising edge of `host_stb` produces exactly one `fpga_cfg_clk` pulse, one clock cycle wide. During that pulse, `shared_bus_o` carries the captured `host_data` byte with `shared_bus_oe` high.
- R4: While loading, `fpga_sel_n`, `fpga_wstb_n` and `fpga_mode_sel` are 0 (parallel-load mode).
- R5: While `fpga_hold` is 1, a pending configuration clock pulse is withheld. It is issued after `fpga_hold` returns to 0.
- R6: If `fpga_clear_n` goes low while loading and `fpga_ready` is low, `cfg_fault` becomes 1. The shared bus is released, and strobes give no clock pulse, even after `fpga_clear_n` returns high. Only a `host_restart` edge clears the fault.
- R7: Once `fpga_ready` is 1 while loading, the block enters bridge mode: `fpga_sel_n` and `fpga_wstb_n` go high, and `shared_bus_o` follows `host_data` one clock later.
- R8: In bridge mode, `host_status[0]`, `[1]` and `[2]` return `fpga_ret[0]`, `[1]` and `[2]` one clock later. Outside bridge mode, `host_status` is 0.
- R9: In bridge mode, while `flash_sel_n` is high, `dot_o` and `dot_oe` are 1 and `shared_bus_oe` is 1. While `flash_sel_n` is low, `shared_bus_oe` and `dot_oe` are 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 8 | Host parallel data lines |
| host_stb | input | 1 | Conditioned host strobe; rising edge loads a byte |
| host_restart | input | 1 | Host request to restart configuration; rising edge |
| host_status | output | 3 | Returned FPGA outputs to host status lines |
| shared_bus_o | output | 8 | Value driven onto the shared flash/display bus |
| shared_bus_oe | output | 1 | Drive enable for the shared bus |
| flash_sel_n | input | 1 | Flash chip-enable as driven by the FPGA, active low |
| dot_o | output | 1 | Decimal-point value (configured indicator) |
| dot_oe | output | 1 | Decimal-point drive enable |
| fpga_cfg_clk | output | 1 | FPGA configuration clock |
| fpga_reset_n | output | 1 | FPGA configuration reset, active low |
| fpga_sel_n | output | 1 | FPGA configuration select, active low |
| fpga_wstb_n | output | 1 | FPGA configuration write strobe, active low |
| fpga_mode_sel | output | 1 | FPGA mode select, 0 = parallel load |
| fpga_clear_n | input | 1 | FPGA memory-clear status, low = clearing or error |
| fpga_ready | input | 1 | FPGA configuration complete |
| fpga_hold | input | 1 | FPGA busy, stalls configuration clock |
| fpga_ret | input | 3 | FPGA outputs returned to the host |
| cfg_fault | output | 1 | Configuration fault flag |

## Verification
The fault state is the hardest to reach. It needs `fpga_clear_n` to fall after the block has left the reset-and-wait phase, while `fpga_ready` is still low. The bench gets there by loading several good bytes and then dropping the clear line. It raises the clear line again to show that the fault is sticky, sends a strobe to show that no clock pulse appears, and only then drives a restart. A second hard case is a strobe that lands while `fpga_hold` is high. The bench holds the hold line for longer than the whole strobe window, and checks that no pulse appears until hold is released.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [2:0] {
        ST_PROG   = 3'd0,
        ST_WINIT  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_WBUSY  = 3'd3,
        ST_STROBE = 3'd4,
        ST_FAULT  = 3'd5,
        ST_LINK   = 3'd6
    } ppb_state_e;

    typedef struct packed {
        logic cfg_clk;
        logic reset_n;
        logic sel_n;
        logic wstb_n;
        logic mode_sel;
    } cfg_ctl_t;

    function automatic logic in_loading(input ppb_state_e s);
        return (s == ST_LOAD) || (s == ST_WBUSY) || (s == ST_STROBE);
    endfunction

    function automatic logic in_cfg_phase(input ppb_state_e s);
        return in_loading(s) || (s == ST_PROG) || (s == ST_WINIT);
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            last_q  <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
            last_q  <= stage_q[STAGES-1];
        end
    end

    assign rise_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pport_cfg_fsm.sv
module pport_cfg_fsm
    import pport_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PROG_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_rise,
    input  logic              restart_rise,
    input  logic [DATA_W-1:0] host_data,
    input  logic              clear_n,
    input  logic              ready,
    input  logic              hold,
    output ppb_state_e        state_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(PROG_LEN + 1);

    ppb_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] byte_q, byte_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        byte_d  = byte_q;
        if (restart_rise) begin
            state_d = ST_PROG;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_PROG: begin
                    if (cnt_q == CNT_W'(PROG_LEN - 1)) state_d = ST_WINIT;
                    else                               cnt_d   = cnt_q + 1'b1;
                end
                ST_WINIT: if (clear_n) state_d = ST_LOAD;
                ST_LOAD, ST_WBUSY, ST_STROBE: begin
                    if (ready)         state_d = ST_LINK;
                    else if (!clear_n) state_d = ST_FAULT;
                    else if (state_q == ST_LOAD) begin
                        if (stb_rise) begin
                            byte_d  = host_data;
                            state_d = ST_WBUSY;
                        end
                    end else if (state_q == ST_WBUSY) begin
                        if (!hold) state_d = ST_STROBE;
                    end else begin
                        state_d = ST_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PROG;
            cnt_q   <= '0;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            byte_q  <= byte_d;
        end
    end

    assign state_o = state_q;
    assign byte_o  = byte_q;
endmodule

// File: rtl/pport_out_stage.sv
module pport_out_stage
    import pport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RET_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ppb_state_e        state,
    input  logic [DATA_W-1:0] cfg_byte,
    input  logic [DATA_W-1:0] host_data,
    input  logic [RET_W-1:0]  fpga_ret,
    input  logic              flash_sel_n,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              dot_o,
    output logic              dot_oe,
    output logic [RET_W-1:0]  status_o,
    output cfg_ctl_t          ctl_o
);
    logic              linked;
    logic              loading;
    logic [DATA_W-1:0] link_q;
    logic [RET_W-1:0]  ret_q;

    assign linked  = (state == ST_LINK);
    assign loading = in_loading(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= '0;
            ret_q  <= '0;
        end else begin
            link_q <= linked ? host_data : '0;
            ret_q  <= linked ? fpga_ret  : '0;
        end
    end

    always_comb begin
        ctl_o.cfg_clk  = (state == ST_STROBE);
        ctl_o.reset_n  = (state != ST_PROG);
        ctl_o.sel_n    = !loading;
        ctl_o.wstb_n   = !loading;
        ctl_o.mode_sel = !in_cfg_phase(state);
    end

    assign bus_o    = loading ? cfg_byte : link_q;
    assign bus_oe   = loading || (linked && flash_sel_n);
    assign dot_o    = linked;
    assign dot_oe   = linked && flash_sel_n;
    assign status_o = ret_q;
endmodule

// File: rtl/pport_cfg_bridge.sv
module pport_cfg_bridge
    import pport_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RET_W    = 3,
    parameter int PROG_LEN = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_stb,
    input  logic              host_restart,
    output logic [RET_W-1:0]  host_status,
    output logic [DATA_W-1:0] shared_bus_o,
    output logic              shared_bus_oe,
    input  logic              flash_sel_n,
    output logic              dot_o,
    output logic              dot_oe,
    output logic              fpga_cfg_clk,
    output logic              fpga_reset_n,
    output logic              fpga_sel_n,
    output logic              fpga_wstb_n,
    output logic              fpga_mode_sel,
    input  logic              fpga_clear_n,
    input  logic              fpga_ready,
    input  logic              fpga_hold,
    input  logic [RET_W-1:0]  fpga_ret,
    output logic              cfg_fault
);
    logic [1:0]        rise;
    ppb_state_e        state;
    logic [DATA_W-1:0] cfg_byte;
    cfg_ctl_t          ctl;

    pport_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({host_restart, host_stb}),
        .rise_o  (rise)
    );

    pport_cfg_fsm #(.DATA_W(DATA_W), .PROG_LEN(PROG_LEN)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stb_rise     (rise[0]),
        .restart_rise (rise[1]),
        .host_data    (host_data),
        .clear_n      (fpga_clear_n),
        .ready        (fpga_ready),
        .hold         (fpga_hold),
        .state_o      (state),
        .byte_o       (cfg_byte)
    );

    pport_out_stage #(.DATA_W(DATA_W), .RET_W(RET_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .cfg_byte    (cfg_byte),
        .host_data   (host_data),
        .fpga_ret    (fpga_ret),
        .flash_sel_n (flash_sel_n),
        .bus_o       (shared_bus_o),
        .bus_oe      (shared_bus_oe),
        .dot_o       (dot_o),
        .dot_oe      (dot_oe),
        .status_o    (host_status),
        .ctl_o       (ctl)
    );

    assign fpga_cfg_clk  = ctl.cfg_clk;
    assign fpga_reset_n  = ctl.reset_n;
    assign fpga_sel_n    = ctl.sel_n;
    assign fpga_wstb_n   = ctl.wstb_n;
    assign fpga_mode_sel = ctl.mode_sel;
    assign cfg_fault     = (state == ST_FAULT);
endmodule

// File: rtl/pport_cfg_bridge_chk.sv
module pport_cfg_bridge_chk #(
    parameter int DATA_W = 8,
    parameter int RET_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] shared_bus_o,
    input logic              shared_bus_oe,
    input logic              flash_sel_n,
    input logic              dot_oe,
    input logic              fpga_cfg_clk,
    input logic              fpga_sel_n,
    input logic              fpga_hold,
    input logic [RET_W-1:0]  host_status,
    input logic              cfg_fault
);
    // R3
    cfg_clk_single_chk: assert property (@(posedge clk) disable iff (rst)
        fpga_cfg_clk |=> !fpga_cfg_clk);

    // R3
    cfg_clk_bus_driven_chk: assert property (@(posedge clk) disable iff (rst)
        fpga_cfg_clk |-> (shared_bus_oe && $stable(shared_bus_o)));

    // R5
    cfg_clk_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fpga_cfg_clk) |-> !$past(fpga_hold));

    // R6
    fault_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_fault |-> (!fpga_cfg_clk && !shared_bus_oe));

    // R8
    status_quiet_load_chk: assert property (@(posedge clk) disable iff (rst)
        !fpga_sel_n |-> (host_status == '0));

    // R9
    flash_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!flash_sel_n && fpga_sel_n) |-> (!shared_bus_oe && !dot_oe));
endmodule

bind pport_cfg_bridge pport_cfg_bridge_chk #(.DATA_W(DATA_W), .RET_W(RET_W)) u_chk (.*);

// File: tb/pport_cfg_bridge_test.sv
module pport_cfg_bridge_test;
    localparam int PROG_LEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_data = '0;
    logic       host_stb = 1'b0;
    logic       host_restart = 1'b0;
    logic [2:0] host_status;
    logic [7:0] shared_bus_o;
    logic       shared_bus_oe;
    logic       flash_sel_n = 1'b1;
    logic       dot_o, dot_oe;
    logic       fpga_cfg_clk, fpga_reset_n, fpga_sel_n, fpga_wstb_n, fpga_mode_sel;
    logic       fpga_clear_n = 1'b0;
    logic       fpga_ready = 1'b0;
    logic       fpga_hold = 1'b0;
    logic [2:0] fpga_ret = '0;
    logic       cfg_fault;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] pulse_bus = '0;
    logic       pulse_ctl_ok = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pport_cfg_bridge #(.PROG_LEN(PROG_LEN)) uut (.*);

    always @(negedge clk) begin
        cycles++;
        if (fpga_cfg_clk) begin
            pulses++;
            pulse_bus    = shared_bus_o;
            pulse_ctl_ok = shared_bus_oe && !fpga_sel_n && !fpga_wstb_n && !fpga_mode_sel;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe_byte(input logic [7:0] b);
        @(negedge clk);
        host_data = b;
        host_stb  = 1'b1;
        repeat (8) @(negedge clk);
        host_stb  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 bus_oe", shared_bus_oe, 0);
        chk("R1 dot_oe", dot_oe, 0);
        chk("R1 cfg_clk", fpga_cfg_clk, 0);
        chk("R1 status", host_status, 0);
    endtask

    task automatic t_program;
        int lows = 0;
        int p0;
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (!fpga_reset_n) lows++;
            @(negedge clk);
        end
        chk("R2 reset pulse length", lows, PROG_LEN);
        p0 = pulses;
        strobe_byte(8'h3C);
        chk("R2 strobe ignored before clear", pulses - p0, 0);
        fpga_clear_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_load(input logic [7:0] b);
        int p0 = pulses;
        strobe_byte(b);
        chk("R3 one pulse per byte", pulses - p0, 1);
        chk("R3 byte on bus", pulse_bus, b);
        chk("R4 load controls", pulse_ctl_ok, 1);
    endtask

    task automatic t_hold;
        int p0 = pulses;
        fpga_hold = 1'b1;
        strobe_byte(8'hC3);
        chk("R5 pulse withheld", pulses - p0, 0);
        fpga_hold = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 pulse released", pulses - p0, 1);
        chk("R5 byte on bus", pulse_bus, 8'hC3);
    endtask

    task automatic t_fault;
        int p0;
        int lows = 0;
        fpga_clear_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 fault set", cfg_fault, 1);
        chk("R6 bus released", shared_bus_oe, 0);
        fpga_clear_n = 1'b1;
        p0 = pulses;
        strobe_byte(8'h77);
        chk("R6 no pulse in fault", pulses - p0, 0);
        chk("R6 fault sticky", cfg_fault, 1);
        host_restart = 1'b1;
        fpga_clear_n = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (!fpga_reset_n) lows++;
        end
        host_restart = 1'b0;
        chk("R2 restart pulse length", lows, PROG_LEN);
        chk("R6 fault cleared", cfg_fault, 0);
        fpga_clear_n = 1'b1;
        repeat (2) @(negedge clk);
        t_load(8'h12);
    endtask

    task automatic t_bridge;
        fpga_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 sel released", fpga_sel_n, 1);
        chk("R7 wstb released", fpga_wstb_n, 1);
        chk("R9 dot lit", {dot_o, dot_oe}, 2'b11);
        chk("R9 bus driven", shared_bus_oe, 1);
        host_data = 8'hA5;
        @(negedge clk);
        chk("R7 data forwarded", shared_bus_o, 8'hA5);
        host_data = 8'h5A;
        @(negedge clk);
        chk("R7 data forwarded", shared_bus_o, 8'h5A);
        fpga_ret = 3'b001;
        @(negedge clk);
        chk("R8 status bit0", host_status, 3'b001);
        fpga_ret = 3'b100;
        @(negedge clk);
        chk("R8 status bit2", host_status, 3'b100);
        fpga_ret = 3'b010;
        @(negedge clk);
        chk("R8 status bit1", host_status, 3'b010);
    endtask

    task automatic t_flash;
        @(negedge clk);
        flash_sel_n = 1'b0;
        #1;
        chk("R9 bus released", shared_bus_oe, 0);
        chk("R9 dot released", dot_oe, 0);
        @(negedge clk);
        flash_sel_n = 1'b1;
        #1;
        chk("R9 bus retaken", shared_bus_oe, 1);
        chk("R9 dot retaken", dot_oe, 1);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_program();
        t_load(8'hFF);
        t_load(8'h00);
        t_load(8'h5A);
        t_load(8'h81);
        t_hold();
        t_fault();
        t_bridge();
        t_flash();
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        finish_run();
    end
endmodule